// File: doc/BRIEF.md
# Tear-Free Control-Voltage Snapshot Register Bank

This block brings a 10-bit value that changes slowly and arrives with no relation to the local clock into the register clock domain. It then exposes that value through a byte-wide register port. The input first passes through a chain of synchronising flops. The bank accepts a new word only when two consecutive synchronised words are identical, so a word caught in mid-transition never reaches software.

The upper two bits of the snapshot sit in one register and the lower eight bits in another. A read of the upper register also copies the current lower byte into a holding register, and a later read of the lower register returns that held byte. Software that reads the upper register first and the lower register second therefore always sees a matched 10-bit pair.

The bank also keeps a writable 10-bit free-run level, split in the same way across two registers, and a control register whose two bits drive the ADC-disable and DAC-disable lines directly.

Top module: `cv_snapshot_regs`

## Requirements
- R1: After `cv_async` has held one value for at least four clock edges, an upper-snapshot read returns that value's bits [9:8].
- R2: While `cv_async` changes on every clock edge, the accepted snapshot does not change. Each synchronised word differs from the one before it, so no two ever agree.
- R3: A read of address 0 (upper snapshot) returns snapshot bits [9:8] in `reg_rdata[1:0]`, with `reg_rdata[7:2]` zero.
- R4: A read of address 0 copies snapshot bits [7:0] into a holding byte. A read of address 1 (lower snapshot) returns that held byte even if the live snapshot has changed since.
- R5: After reset and before the first address-0 read, an address-1 read returns 0x00.
- R6: After reset, `free_val` is 0x1FF: address 2 (free-run upper) reads 0x01 and address 3 (free-run lower) reads 0xFF.
- R7: A write to address 3 sets `free_val[7:0]`. A write to address 2 sets `free_val[9:8]` from `reg_wdata[1:0]` and discards `reg_wdata[7:2]`, which read back as zero.
- R8: Address 4 is the disable register. Bit 1 drives `adc_disable` and bit 0 drives `dac_disable`. Both reset to 0 (enabled), and the register reads back `{6'b0, adc, dac}`.
- R9: Writes to addresses 0 and 1 have no effect on the values those addresses return.
- R10: `reg_rdata` is registered. It is valid on the cycle after `reg_rd` is high and is zero in every other cycle. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| cv_async | input | 10 | Asynchronous slowly changing value |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the read strobe |
| free_val | output | 10 | Free-run level |
| adc_disable | output | 1 | ADC disable line |
| dac_disable | output | 1 | DAC disable line |

## Verification
The hardest situation to reach from the ports is an input that never settles, where every pair of synchronised words differs and the snapshot has to stay frozen. The bench drives two values that differ in both bytes, alternating on every clock edge for many cycles. It then issues an upper-snapshot read while the final value is still inside the flop chain. That read must still return the older value, and a read after the chain settles must return the new one. Random settled values, each followed by a change of input between the upper and lower reads, exercise the coherence of the held byte.

// File: rtl/cvsnap_pkg.sv
package cvsnap_pkg;
    localparam int VAL_W  = 10;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int HI_W   = VAL_W - DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_SNAP_HI = 3'd0,
        REG_SNAP_LO = 3'd1,
        REG_FREE_HI = 3'd2,
        REG_FREE_LO = 3'd3,
        REG_DISABLE = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic adc_off;
        logic dac_off;
    } disable_t;

    localparam logic [VAL_W-1:0] FREE_RESET = 10'h1FF;

    function automatic logic [DATA_W-1:0] upper_to_byte(input logic [VAL_W-1:0] v);
        return {{(DATA_W-HI_W){1'b0}}, v[VAL_W-1:DATA_W]};
    endfunction
endpackage

// File: rtl/cvs_sync.sv
module cvs_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sampled
);
    logic [STAGES-1:0][W-1:0] chain;
    logic [W-1:0]             prev_q;
    logic [W-1:0]             sync_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_w = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            sampled <= '0;
        end else begin
            prev_q <= sync_w;
            if (sync_w == prev_q) sampled <= sync_w;
        end
    end

    // R1/R2: a new snapshot equals the word that was already in the compare stage
    assert_agree_update_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sampled) |-> sampled == $past(prev_q));
endmodule

// File: rtl/cvs_hold.sv
module cvs_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] live_lo,
    output logic [DATA_W-1:0] held_lo
);
    always_ff @(posedge clk) begin
        if (rst)          held_lo <= '0;
        else if (capture) held_lo <= live_lo;
    end

    assert_hold_on_upper_read_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(held_lo) |-> $past(capture));
endmodule

// File: rtl/cvs_cfg.sv
module cvs_cfg
    import cvsnap_pkg::*;
#(
    parameter int                VAL_W  = 10,
    parameter int                DATA_W = 8,
    parameter logic [VAL_W-1:0]  RST_VAL = 10'h1FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [VAL_W-1:0]  free_val,
    output disable_t          dis
);
    localparam int UP_W = VAL_W - DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_val <= RST_VAL;
            dis      <= '0;
        end else if (wr) begin
            case (addr)
                REG_FREE_HI: free_val[VAL_W-1:DATA_W] <= wdata[UP_W-1:0];
                REG_FREE_LO: free_val[DATA_W-1:0]     <= wdata;
                REG_DISABLE: dis <= disable_t'(wdata[1:0]);
                default: ;
            endcase
        end
    end

    assert_free_hi_write_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(free_val[VAL_W-1:DATA_W]) |-> $past(wr && addr == REG_FREE_HI));
    assert_disable_reset_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> dis == '0);
endmodule

// File: rtl/cv_snapshot_regs.sv
module cv_snapshot_regs
    import cvsnap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VAL_W-1:0]  cv_async,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [VAL_W-1:0]  free_val,
    output logic              adc_disable,
    output logic              dac_disable
);
    logic [VAL_W-1:0]  snap;
    logic [DATA_W-1:0] held_lo;
    logic              upper_rd;
    disable_t          dis;
    logic [DATA_W-1:0] rd_mux;

    assign upper_rd = reg_rd && (reg_addr == REG_SNAP_HI);

    cvs_sync #(.W(VAL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(cv_async), .sampled(snap));

    cvs_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .capture(upper_rd),
        .live_lo(snap[DATA_W-1:0]), .held_lo(held_lo));

    cvs_cfg #(.VAL_W(VAL_W), .DATA_W(DATA_W), .RST_VAL(FREE_RESET)) u_cfg (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .free_val(free_val), .dis(dis));

    assign adc_disable = dis.adc_off;
    assign dac_disable = dis.dac_off;

    always_comb begin
        case (reg_addr)
            REG_SNAP_HI: rd_mux = upper_to_byte(snap);
            REG_SNAP_LO: rd_mux = held_lo;
            REG_FREE_HI: rd_mux = upper_to_byte(free_val);
            REG_FREE_LO: rd_mux = free_val[DATA_W-1:0];
            REG_DISABLE: rd_mux = {{(DATA_W-2){1'b0}}, dis};
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
        else             reg_rdata <= '0;
    end

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $past(reg_rd && reg_addr == REG_SNAP_HI) |-> reg_rdata[DATA_W-1:HI_W] == '0);
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        $past(!reg_rd) |-> reg_rdata == '0);
endmodule

// File: tb/tb_cv_snapshot_regs.sv
module tb_cv_snapshot_regs;
    logic       clk = 0;
    logic       rst = 1;
    logic [9:0] cv_async = '0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [9:0] free_val;
    logic       adc_disable, dac_disable;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cv_snapshot_regs dut (
        .clk(clk), .rst(rst), .cv_async(cv_async), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .free_val(free_val),
        .adc_disable(adc_disable), .dac_disable(dac_disable));

    function automatic logic [7:0] exp_hi(input logic [9:0] v);
        return {6'b0, v[9:8]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic settle(input logic [9:0] v);
        @(negedge clk); cv_async = v;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [9:0] a, b, fv;
        logic [1:0] dv;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R10 reset rdata", reg_rdata, 0);
        chk("R6 free reset", free_val, 10'h1FF);
        chk("R8 disable reset", {adc_disable, dac_disable}, 0);
        rd(3'd2, d); chk("R6 free hi reset", d, 8'h01);
        rd(3'd3, d); chk("R6 free lo reset", d, 8'hFF);
        rd(3'd4, d); chk("R8 disable readback reset", d, 8'h00);
        settle(10'h2A5);
        rd(3'd1, d); chk("R5 held before first upper read", d, 8'h00);
        rd(3'd0, d); chk("R1 R3 upper read", d, exp_hi(10'h2A5));
        rd(3'd1, d); chk("R4 lower read", d, 8'hA5);
        // R9: writes to snapshot registers ignored
        wr(3'd0, 8'hFF); wr(3'd1, 8'h3C);
        rd(3'd1, d); chk("R9 lower after write", d, 8'hA5);
        rd(3'd0, d); chk("R9 upper after write", d, exp_hi(10'h2A5));
        // R10: unmapped addresses and idle cycle
        rd(3'd5, d); chk("R10 addr5", d, 0);
        rd(3'd7, d); chk("R10 addr7", d, 0);
        @(negedge clk); chk("R10 idle zero", reg_rdata, 0);
        // R2: input toggling every edge never accepted
        a = 10'h1C3; b = 10'h23C;
        settle(a);
        for (int i = 0; i < 30; i++) begin
            cv_async = (i % 2 == 0) ? b : a;
            @(negedge clk);
        end
        cv_async = b;
        rd(3'd0, d); chk("R2 frozen upper during toggle", d, exp_hi(a));
        rd(3'd1, d); chk("R2 frozen lower during toggle", d, a[7:0]);
        repeat (6) @(negedge clk);
        rd(3'd0, d); chk("R1 upper after settle", d, exp_hi(b));
        // R4: held byte survives a change of input
        settle(10'h0F0);
        rd(3'd1, d); chk("R4 held not live", d, b[7:0]);
        // R7 directed: upper bits of free hi discarded
        wr(3'd2, 8'hFE);
        chk("R7 free hi bits", free_val[9:8], 2'b10);
        rd(3'd2, d); chk("R7 free hi readback", d, 8'h02);
        // random mix
        for (int n = 0; n < 40; n++) begin
            a = 10'($urandom);
            b = 10'($urandom);
            settle(a);
            rd(3'd0, d); chk("R1 R3 random upper", d, exp_hi(a));
            settle(b);
            rd(3'd1, d); chk("R4 random held lower", d, a[7:0]);
            fv = 10'($urandom);
            dv = 2'($urandom);
            wr(3'd2, {6'($urandom), fv[9:8]});
            wr(3'd3, fv[7:0]);
            wr(3'd4, {6'($urandom), dv});
            chk("R7 random free_val", free_val, fv);
            chk("R8 random disable pins", {adc_disable, dac_disable}, dv);
            rd(3'd4, d); chk("R8 random disable readback", d, {6'b0, dv});
            rd(3'd3, d); chk("R7 random free lo readback", d, fv[7:0]);
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule